// File: doc/BRIEF.md
# Hierarchical Hit Timestamp Encoder

This block turns a detector hit into a fine-grained arrival time. It runs a free-running coarse counter on the reference clock. When a hit arrives, it stamps the hit with that counter value and with three finer interpolation fields. The first field is a phase index that splits each reference period into eight parts. The second comes from a snapshot of a 32-cell delay line, which splits each phase bin into 32 parts. The third comes from a 4-tap resistor-capacitor snapshot, which splits each delay-line bin into four parts. With the default widths the result is a 21-bit word. From the least significant end its fields are the RC code, the delay-line index, the phase index and the coarse count.

The delay-line and RC snapshots arrive as digital thermometer codes, meaning a run of ones followed by zeros. The block decodes them into binary. The analog cells, the clock multiplier and any nonlinearity correction sit outside the block.

The output is a stream with a valid flag and no ready. A hit cannot be delayed, so the receiver has no back-pressure. It must accept every cycle in which `ts_valid_o` is high. Between hits, `ts_o` holds the last stamp.

Top module: `hit_stamp_enc`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it drops, `ts_valid_o` is 0. The coarse counter restarts from 0 on the first edge after reset.
- R2: The coarse counter advances by one on every clock edge. It wraps from its maximum value (2047 at the default width) to 0 with no other indication.
- R3: The coarse field of a stamp equals the counter value present at the edge that samples the hit. The coarse field occupies the top COARSE_W bits of `ts_o`.
- R4: `pll_phase_i` is copied unchanged into bits [9:7] of `ts_o`, just above the delay-line field.
- R5: The delay-line field, in bits [6:2], is the number of consecutive ones starting from tap 0. An all-zero snapshot gives 0. An all-ones snapshot saturates at 31.
- R6: A bubble in the delay-line snapshot is resolved at the first zero found from tap 0. For example, taps 0..2 high, tap 3 low and tap 4 high gives index 3.
- R7: The RC field, in bits [1:0], is the count of ones in `rc_taps_i`, saturated at 3.
- R8: A rising edge on `hit_i` makes `ts_valid_o` high for exactly one cycle, in the cycle after the sampling edge.
- R9: While `hit_i` stays high after its rising edge, no further stamp is produced, and `ts_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (40 MHz in the target system) |
| rst_i | input | 1 | Synchronous reset, active high |
| hit_i | input | 1 | Hit strobe; its rising edge is stamped |
| pll_phase_i | input | PLL_W | Phase index of the multiplied clock |
| dll_taps_i | input | DLL_TAPS | Delay-line thermometer snapshot; bit 0 is tap 0 |
| rc_taps_i | input | RC_TAPS | RC interpolation thermometer snapshot |
| ts_o | output | TS_W | Packed timestamp: {coarse, phase, delay-line index, RC code} |
| ts_valid_o | output | 1 | High for one cycle when `ts_o` holds a new stamp |

## Verification
The bench builds the block with COARSE_W = 6 and keeps the default interpolation widths. This brings the counter wrap from 63 to 0 within a few dozen cycles, so stamps taken on both sides of the wrap can be compared. The full 32-tap decoder stays intact, so the saturating all-ones snapshot and bubbled snapshots are exercised at the real field width. A held hit strobe is also checked, to confirm that it yields a single stamp.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;
  localparam int HS_COARSE_W_DEF = 11;
  localparam int HS_PLL_W_DEF    = 3;
  localparam int HS_DLL_TAPS_DEF = 32;
  localparam int HS_RC_TAPS_DEF  = 4;
endpackage

// File: rtl/hs_coarse_ctr.sv
module hs_coarse_ctr #(
  parameter int WIDTH = 11
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> cnt_q == WIDTH'($past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/hs_therm_dec.sv
module hs_therm_dec #(
  parameter int TAPS = 32,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  therm_i,
  output logic [IDX_W-1:0] idx_o
);
  logic found;

  always_comb begin
    idx_o = IDX_W'(TAPS - 1);
    found = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (!found && !therm_i[i]) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (therm_i != '1 && ((therm_i & (therm_i + 1'b1)) == '0))
      AST_THERM_CLEAN: assert (idx_o == IDX_W'($countones(therm_i))); // R5
  end
endmodule

// File: rtl/hs_rc_count.sv
module hs_rc_count #(
  parameter int TAPS = 4,
  localparam int CODE_W = $clog2(TAPS),
  localparam int MAXV = (1 << CODE_W) - 1
) (
  input  logic [TAPS-1:0]   taps_i,
  output logic [CODE_W-1:0] code_o
);
  int ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < TAPS; i++) ones = ones + int'(taps_i[i]);
    code_o = CODE_W'((ones > MAXV) ? MAXV : ones);
  end

  always_comb begin
    if ($countones(taps_i) >= MAXV)
      AST_RC_SAT: assert (code_o == CODE_W'(MAXV)); // R7
  end
endmodule

// File: rtl/hit_stamp_enc.sv
module hit_stamp_enc
  import hit_stamp_pkg::*;
#(
  parameter int COARSE_W = HS_COARSE_W_DEF,
  parameter int PLL_W    = HS_PLL_W_DEF,
  parameter int DLL_TAPS = HS_DLL_TAPS_DEF,
  parameter int RC_TAPS  = HS_RC_TAPS_DEF,
  localparam int DLL_W = $clog2(DLL_TAPS),
  localparam int RC_W  = $clog2(RC_TAPS),
  localparam int TS_W  = COARSE_W + PLL_W + DLL_W + RC_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                hit_i,
  input  logic [PLL_W-1:0]    pll_phase_i,
  input  logic [DLL_TAPS-1:0] dll_taps_i,
  input  logic [RC_TAPS-1:0]  rc_taps_i,
  output logic [TS_W-1:0]     ts_o,
  output logic                ts_valid_o
);
  logic [COARSE_W-1:0] coarse;
  logic [DLL_W-1:0]    dll_idx;
  logic [RC_W-1:0]     rc_code;
  logic                hit_q;
  logic                hit_rise;
  logic [TS_W-1:0]     ts_q;
  logic                valid_q;

  hs_coarse_ctr #(.WIDTH(COARSE_W)) u_ctr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_o (coarse)
  );

  hs_therm_dec #(.TAPS(DLL_TAPS)) u_dll (
    .therm_i (dll_taps_i),
    .idx_o   (dll_idx)
  );

  hs_rc_count #(.TAPS(RC_TAPS)) u_rc (
    .taps_i (rc_taps_i),
    .code_o (rc_code)
  );

  assign hit_rise = hit_i & ~hit_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hit_q   <= 1'b0;
      valid_q <= 1'b0;
      ts_q    <= '0;
    end else begin
      hit_q   <= hit_i;
      valid_q <= hit_rise;
      if (hit_rise) ts_q <= {coarse, pll_phase_i, dll_idx, rc_code};
    end
  end

  assign ts_o       = ts_q;
  assign ts_valid_o = valid_q;

  AST_VALID_AFTER_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_i && !hit_q) |=> ts_valid_o); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    ts_valid_o |=> !ts_valid_o); // R8
  AST_HOLD_NO_STAMP: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_i && hit_q) |=> (!ts_valid_o && $stable(ts_o))); // R9
  AST_COARSE_FIELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_i && !hit_q) |=> ts_o[TS_W-1 -: COARSE_W] == $past(coarse)); // R3
endmodule

// File: tb/hit_stamp_enc_bench.sv
module hit_stamp_enc_bench;
  localparam int CW = 6;
  localparam int TW = CW + 3 + 5 + 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          hit;
  logic [2:0]    pll;
  logic [31:0]   dll;
  logic [3:0]    rc;
  logic [TW-1:0] ts;
  logic          vld;
  logic [CW-1:0] mc;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hit_stamp_enc #(.COARSE_W(CW)) u_hit_stamp_enc (
    .clk_i(clk), .rst_i(rst), .hit_i(hit), .pll_phase_i(pll),
    .dll_taps_i(dll), .rc_taps_i(rc), .ts_o(ts), .ts_valid_o(vld)
  );

  always @(posedge clk) mc <= rst ? '0 : CW'(mc + 1'b1);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_hit(input logic [2:0] p, input logic [31:0] d, input logic [3:0] r,
                        input logic [4:0] ed, input logic [1:0] er, input string tag);
    logic [CW-1:0] ec;
    logic [TW-1:0] ets;
    @(negedge clk);
    pll = p; dll = d; rc = r; hit = 1'b1;
    ec = mc;
    @(negedge clk);
    hit = 1'b0;
    ets = {ec, p, ed, er};
    check(vld === 1'b1, {tag, " R8 valid"}, 32'(vld), 1);
    check(ts === ets, tag, 32'(ts), 32'(ets));
    @(negedge clk);
    check(vld === 1'b0, {tag, " R8 single"}, 32'(vld), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; hit = 1'b0; pll = '0; dll = '0; rc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vld === 1'b0, "R1 valid in reset", 32'(vld), 0);
    rst = 1'b0;
    @(negedge clk);
    check(vld === 1'b0, "R1 valid after reset", 32'(vld), 0);
  endtask

  task automatic t_fields();
    do_hit(3'd5, 32'h0000_00FF, 4'b0011, 5'd8, 2'd2, "R3 R4 R5 R7 basic");
    do_hit(3'd0, 32'h0000_0000, 4'b0000, 5'd0, 2'd0, "R5 all zero");
    do_hit(3'd7, 32'hFFFF_FFFF, 4'b1111, 5'd31, 2'd3, "R5 R7 saturate");
    do_hit(3'd2, 32'h7FFF_FFFF, 4'b0001, 5'd31, 2'd1, "R5 31 ones");
    do_hit(3'd3, 32'h0000_0017, 4'b0111, 5'd3, 2'd3, "R6 bubble");
    do_hit(3'd6, 32'hF000_0001, 4'b0101, 5'd1, 2'd2, "R6 far bubble");
  endtask

  task automatic t_wrap();
    while (mc != CW'((1 << CW) - 2)) @(negedge clk);
    do_hit(3'd1, 32'h0000_000F, 4'b0001, 5'd4, 2'd1, "R2 R3 at max");
    while (mc != '0) @(negedge clk);
    @(posedge clk);
    while (mc != CW'((1 << CW) - 1)) @(negedge clk);
    do_hit(3'd4, 32'h0000_0001, 4'b0000, 5'd1, 2'd0, "R2 wrap zero");
  endtask

  task automatic t_hold();
    logic [TW-1:0] prev;
    int nv = 0;
    do_hit(3'd2, 32'h0000_003F, 4'b0011, 5'd6, 2'd2, "R9 seed");
    prev = ts;
    @(negedge clk);
    hit = 1'b1; pll = 3'd7; dll = 32'h0000_0003; rc = 4'b1111;
    @(negedge clk);
    check(vld === 1'b1, "R8 hold rise", 32'(vld), 1);
    prev = ts;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pll = 3'(i); dll = 32'h0000_FFFF;
      if (vld) nv++;
    end
    check(nv == 0, "R9 no extra valid", 32'(nv), 0);
    check(ts === prev, "R9 ts held", 32'(ts), 32'(prev));
    hit = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fields();
    t_wrap();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule